// File: doc/BRIEF.md
# Sticky Status and Dual-Mask Interrupt Unit

This block keeps the status word of a card-interface controller. The low eleven bits are sticky event flags. The data path raises them with one-cycle pulses, and software lowers them with a write-one-to-clear access. The next eleven bits carry live FIFO and engine flags. These are registered once from the data path and cannot be cleared. Two independent mask registers each select a subset of the 22-bit word, and each mask drives one registered level interrupt line.

The block also holds a refill interlock. When software pops a word from the data FIFO, the block raises a stall towards the data engine. The stall stays up until software polls either the status word or the FIFO-count register. That poll drops the stall and sends a one-cycle kick, so the engine runs again. A poll returns the status word as it stood before the access, and the poll itself never changes that word.

Top module: `sts_irq_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, the sticky bits, the live copy, both masks, both interrupt lines, the stall and the kick are all zero until new stimulus arrives.
- R2: A high bit on evt_set_i sets the matching sticky bit at the next clock edge. Bits 0 to 8 and bit 10 are events. Bit 9 is reserved and always reads 0.
- R3: status_o bits 10:0 are the sticky bits. Bits 21:11 are live_i as sampled at the previous clock edge.
- R4: A cycle with clr_we_i high clears each sticky bit whose wdata_i bit in 10:0 is 1. wdata_i bits 21:11 have no effect on the clear, and the live bits cannot be cleared.
- R5: If a set and a clear hit the same sticky bit in the same cycle, the bit ends up set.
- R6: msk_we_i[i] high loads wdata_i[21:0] into mask i at the clock edge.
- R7: irq_o[i] is registered. It equals the OR of (status_o AND mask i) as they stood one cycle earlier, and it is low whenever mask i was zero.
- R8: fifo_rd_i raises stall_o at the next edge. stall_o stays high through idle cycles until a poll arrives.
- R9: stat_rd_i or cnt_rd_i while stall_o is high drops stall_o at the next edge and pulses kick_o for exactly one cycle. A poll while stall_o is low gives no kick. A poll never changes status_o.
- R10: fifo_rd_i together with a poll in the same cycle leaves stall_o high and gives no kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_set_i | input | 11 | Sticky event pulses, one bit per event |
| live_i | input | 11 | Live FIFO and engine flags, shown in status bits 21:11 |
| wdata_i | input | 22 | Write data for the clear and mask writes |
| clr_we_i | input | 1 | Write-one-to-clear strobe |
| msk_we_i | input | 2 | Mask write strobes, one per interrupt line |
| stat_rd_i | input | 1 | Status register read strobe |
| cnt_rd_i | input | 1 | FIFO-count register read strobe |
| fifo_rd_i | input | 1 | FIFO data word read strobe |
| status_o | output | 22 | Status word: live flags above sticky flags |
| irq_o | output | 2 | Registered level interrupt lines |
| stall_o | output | 1 | Holds the data engine after a FIFO read |
| kick_o | output | 1 | One-cycle request for the engine to run again |

## Verification
The bench builds the unit with its default parameters: eleven sticky bits with bit 9 reserved, eleven live bits and two interrupt lines. With these values every bit of the 22-bit word can be reached. That covers the reserved bit, the boundary between the clearable and the live halves at bit 11, and the top live bit that the upper mask bits select. Two lines are enough to show that the masks act independently, and that one clear drops one line while the other stays high.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int STICKY_W = 11;
  localparam int LIVE_W   = 11;
  localparam int STATUS_W = STICKY_W + LIVE_W;
  localparam int N_IRQ    = 2;
  // bit 9 reserved
  localparam logic [STICKY_W-1:0] EVT_VALID = 11'h5FF;
endpackage

// File: rtl/sts_sticky.sv
module sts_sticky #(
  parameter int              W     = 11,
  parameter logic [W-1:0]    VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sticky_o
);
  logic [W-1:0] q, clr_m, nxt;

  always_comb begin
    clr_m = clr_we_i ? clr_i : '0;
    nxt   = ((q & ~clr_m) | set_i) & VALID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign sticky_o = q;

  // R4
  no_spurious_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(q) & ~q & ~($past(clr_we_i) ? $past(clr_i) : {W{1'b0}})) == {W{1'b0}}));
  // R2
  no_spurious_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q & ~$past(q) & ~$past(set_i)) == {W{1'b0}}));
  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q & $past(set_i & VALID)) == $past(set_i & VALID)));
endmodule

// File: rtl/sts_irq_line.sv
module sts_irq_line #(
  parameter int W = 22
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] status_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_i;
      irq_q <= |(status_i & mask_q);
    end
  end

  assign irq_o = irq_q;

  // R7
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mask_q) == {W{1'b0}}) |-> !irq_o);
  // R6
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mask_we_i) |-> (mask_q == $past(mask_i)));
endmodule

// File: rtl/sts_refill_gate.sv
module sts_refill_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fifo_rd_i,
  input  logic poll_i,
  output logic stall_o,
  output logic kick_o
);
  logic hold_q, kick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      kick_q <= 1'b0;
    end else begin
      // a pop in the same cycle as the poll re-arms the hold
      hold_q <= fifo_rd_i | (hold_q & ~poll_i);
      kick_q <= hold_q & poll_i & ~fifo_rd_i;
    end
  end

  assign stall_o = hold_q;
  assign kick_o  = kick_q;

  // R8
  hold_after_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fifo_rd_i) |-> stall_o);
  // R9
  kick_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |-> (!stall_o && $past(stall_o)));
  // R9
  kick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |=> !kick_o);
endmodule

// File: rtl/sts_irq_unit.sv
module sts_irq_unit
  import sts_pkg::*;
#(
  parameter int                   STK_W = STICKY_W,
  parameter int                   LVE_W = LIVE_W,
  parameter int                   NIRQ  = N_IRQ,
  parameter logic [STK_W-1:0]     VALID = EVT_VALID
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [STK_W-1:0]         evt_set_i,
  input  logic [LVE_W-1:0]         live_i,
  input  logic [STK_W+LVE_W-1:0]   wdata_i,
  input  logic                     clr_we_i,
  input  logic [NIRQ-1:0]          msk_we_i,
  input  logic                     stat_rd_i,
  input  logic                     cnt_rd_i,
  input  logic                     fifo_rd_i,
  output logic [STK_W+LVE_W-1:0]   status_o,
  output logic [NIRQ-1:0]          irq_o,
  output logic                     stall_o,
  output logic                     kick_o
);
  localparam int SW = STK_W + LVE_W;

  logic [STK_W-1:0] sticky;
  logic [LVE_W-1:0] live_q;
  logic [SW-1:0]    status;

  sts_sticky #(.W(STK_W), .VALID(VALID)) u_sticky (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (evt_set_i),
    .clr_we_i (clr_we_i),
    .clr_i    (wdata_i[STK_W-1:0]),
    .sticky_o (sticky)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= '0;
    else         live_q <= live_i;
  end

  assign status   = {live_q, sticky};
  assign status_o = status;

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    sts_irq_line #(.W(SW)) u_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .status_i  (status),
      .mask_we_i (msk_we_i[i]),
      .mask_i    (wdata_i),
      .irq_o     (irq_o[i])
    );
  end

  sts_refill_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_rd_i (fifo_rd_i),
    .poll_i    (stat_rd_i | cnt_rd_i),
    .stall_o   (stall_o),
    .kick_o    (kick_o)
  );

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o[STK_W-1:0] & ~VALID) == {STK_W{1'b0}}));
  // R9
  poll_keeps_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_rd_i | cnt_rd_i) && !$past(clr_we_i) && ($past(evt_set_i) == '0))
      |-> (status_o[STK_W-1:0] == $past(status_o[STK_W-1:0])));
endmodule

// File: tb/sim_sts_irq_unit.sv
module sim_sts_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] evt = '0;
  logic [10:0] live = '0;
  logic [21:0] wdata = '0;
  logic        clr_we = 1'b0;
  logic [1:0]  msk_we = '0;
  logic        stat_rd = 1'b0, cnt_rd = 1'b0, fifo_rd = 1'b0;
  logic [21:0] status;
  logic [1:0]  irq;
  logic        stall, kick;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sts_irq_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_set_i(evt), .live_i(live), .wdata_i(wdata),
    .clr_we_i(clr_we), .msk_we_i(msk_we), .stat_rd_i(stat_rd), .cnt_rd_i(cnt_rd),
    .fifo_rd_i(fifo_rd), .status_o(status), .irq_o(irq), .stall_o(stall), .kick_o(kick)
  );

  // {evt, clr_we, wdata, live, expected status}
  localparam logic [66:0] VEC [0:7] = '{
    {11'h001, 1'b0, 22'h000000, 11'h000, 22'h000001},
    {11'h240, 1'b0, 22'h000000, 11'h003, 22'h001841},
    {11'h000, 1'b1, 22'h000001, 11'h000, 22'h000040},
    {11'h040, 1'b1, 22'h000040, 11'h400, 22'h200040},
    {11'h000, 1'b1, 22'h3FF800, 11'h7FF, 22'h3FF840},
    {11'h7FF, 1'b0, 22'h000000, 11'h000, 22'h0005FF},
    {11'h000, 1'b1, 22'h0007FF, 11'h000, 22'h000000},
    {11'h100, 1'b0, 22'h000000, 11'h010, 22'h008100}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FIFO-unit FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    evt = '0; clr_we = 1'b0; msk_we = '0; stat_rd = 1'b0; cnt_rd = 1'b0; fifo_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FIFO-unit FAIL watchdog: got hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", 32'(status), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 stall/kick", {30'd0, stall, kick}, 0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", 32'(status), 0);

    // R2 R3 R4 R5: table walk
    for (int i = 0; i < 8; i++) begin
      {evt, clr_we, wdata, live} = VEC[i][66:22];
      step();
      chk($sformatf("R2/R3/R4/R5 vec %0d", i), 32'(status), 32'(VEC[i][21:0]));
    end
    idle();

    // R6 R7: sticky 0x100, live bit 4 held
    msk_we = 2'b01; wdata = 22'h000100;
    step();
    idle();
    chk("R7 one-cycle delay", 32'(irq), 0);
    step();
    chk("R6 mask0", 32'(irq), 32'h1);
    msk_we = 2'b10; wdata = 22'h008000;
    step();
    idle();
    step();
    chk("R6 mask1 live bit", 32'(irq), 32'h3);
    clr_we = 1'b1; wdata = 22'h000100;
    step();
    idle();
    chk("R7 irq lags clear", 32'(irq), 32'h3);
    step();
    chk("R7 irq0 drops", 32'(irq), 32'h2);
    msk_we = 2'b10; wdata = 22'h0;
    step();
    idle();
    step();
    chk("R7 zero mask", 32'(irq), 0);
    live = '0;
    step();

    // R8 R9 R10
    fifo_rd = 1'b1;
    step();
    idle();
    chk("R8 stall set", 32'(stall), 1);
    step(); step();
    chk("R8 stall held", 32'(stall), 1);
    stat_rd = 1'b1;
    step();
    idle();
    chk("R9 status poll releases", {30'd0, stall, kick}, 32'h1);
    step();
    chk("R9 kick one cycle", 32'(kick), 0);
    fifo_rd = 1'b1;
    step();
    idle();
    cnt_rd = 1'b1;
    step();
    idle();
    chk("R9 count poll releases", {30'd0, stall, kick}, 32'h1);
    stat_rd = 1'b1;
    step();
    idle();
    chk("R9 poll without hold", {30'd0, stall, kick}, 0);
    fifo_rd = 1'b1;
    step();
    fifo_rd = 1'b1; stat_rd = 1'b1;
    step();
    idle();
    chk("R10 pop with poll", {30'd0, stall, kick}, 32'h2);
    stat_rd = 1'b1;
    step();
    idle();
    evt = 11'h004;
    step();
    idle();
    stat_rd = 1'b1;
    step();
    idle();
    chk("R9 poll keeps status", 32'(status), 32'h4);

    // R1: reset mid-run clears masks and hold
    msk_we = 2'b11; wdata = 22'h3FFFFF;
    step();
    idle();
    fifo_rd = 1'b1;
    step();
    idle();
    rst_n = 1'b0;
    #1;
    chk("R1 reset status", 32'(status), 0);
    chk("R1 reset stall/irq", {29'd0, stall, irq}, 0);
    step();
    rst_n = 1'b1;
    evt = 11'h001;
    step();
    idle();
    step();
    chk("R1 masks cleared", 32'(irq), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule